// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block holds the pending, in-service and trigger-kind state for a processor's vectored interrupts. Each vector number doubles as its priority, and priority classes are groups of sixteen vectors. Requests arrive on a valid/ready stream tagged edge or level. A task-priority register and the highest in-service vector together give the processor priority. A level-sensitive interrupt line tells the CPU when an acknowledge would return a real vector.

The CPU pulses an acknowledge strobe. One cycle later the block answers with one of three results: the granted vector, the spurious vector held in the low byte of the spurious/enable register, or a "no vector" flag. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level-triggered, and directed end-of-interrupt is not selected, the block emits a one-cycle broadcast notice that carries the vector.

The request stream never applies back-pressure: `req_ready` is always high, and a request is taken on every cycle in which `req_valid` is high. The acknowledge answer and the broadcast notice are single-cycle pulses with no ready. The consumer must take them in the cycle they appear.

Top module: `vec_prio_core`

## Requirements
- R1: Among the pending vectors, the highest number has the highest priority. Successive acknowledge/EOI pairs return the pending vectors in descending order.
- R2: A request sets the pending bit of its vector. A level request sets the vector's trigger bit and an edge request clears it. Only the trigger bit decides whether the later EOI of that vector broadcasts. `req_ready` is always 1.
- R3: The processor priority is computed from the task priority `tpr` and the class `ic`, where `ic` is bits 7:4 of the highest in-service vector, or 0 when nothing is in service. If `tpr[7:4] >= ic`, the processor priority equals `tpr`. Otherwise it equals `{ic,4'h0}`. It is read with `reg_sel`=2.
- R4: When bit 8 (enable) of the spurious register is clear, or nothing is pending, `irq` is low. In that state an acknowledge returns `ack_none`=1.
- R5: A pending vector is held off when the processor priority is nonzero and the vector's class is at or below the processor priority class. While held off, `irq` is low and an acknowledge returns `ack_spurious`=1 with `ack_vector` equal to spurious register bits 7:0.
- R6: A granted acknowledge clears the vector's pending bit and sets its in-service bit. It returns the vector with both flags low, with `ack_valid` in the cycle after the strobe.
- R7: EOI clears only the highest in-service bit, and does nothing when none is set. When that vector's trigger bit is set and bit 12 (directed EOI) of the spurious register is clear, the cycle after the strobe shows `beoi_valid`=1 with `beoi_vector` equal to that vector.
- R8: Writes to the spurious register (`reg_sel`=1) keep bits 12 and 8:0 and store zero elsewhere. A write with `reg_sel`=0 sets `tpr` from `reg_wdata[7:0]`. Reset values are `tpr`=0 and spurious register 0x00FF.
- R9: A request and an EOI in the same cycle are both applied, the request first. A same-cycle edge request for the in-service vector therefore suppresses that vector's broadcast.
- R10: `irq` is high exactly when an acknowledge would grant. It follows the registered state, so it reflects a change in the cycle after the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready, always 1 |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge |
| ack_strobe | input | 1 | CPU acknowledge |
| ack_valid | output | 1 | Acknowledge answer present |
| ack_vector | output | 8 | Granted or spurious vector |
| ack_spurious | output | 1 | Answer is the spurious vector |
| ack_none | output | 1 | Nothing was pending |
| eoi_strobe | input | 1 | End of interrupt |
| beoi_valid | output | 1 | Broadcast EOI notice |
| beoi_vector | output | 8 | Vector of the broadcast notice |
| irq | output | 1 | Interrupt line to the CPU |
| reg_wr | input | 1 | Register write enable |
| reg_sel | input | 2 | 0 task priority, 1 spurious/enable, 2 processor priority (read only) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` |

## Verification
Acknowledge answers and broadcast notices are registered, so each one is due exactly one clock after its strobe. Pending and in-service changes show on `irq` and on the processor-priority readback after that same edge. Register reads are combinational from the stored state.

Every bench operation drives its inputs after a falling edge, waits one rising edge, and samples at the next falling edge. Each result is therefore read in the cycle it is due and never later. The sweeps request each of the 256 vectors and try each of the 256 task-priority values against a fixed vector, and the expected outcomes are computed from the class arithmetic.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int SVR_EN_BIT   = 8;
  localparam int SVR_DEOI_BIT = 12;
  localparam logic [15:0] SVR_KEEP  = 16'h11FF;
  localparam logic [15:0] SVR_RESET = 16'h00FF;

  typedef enum logic [1:0] {
    SEL_TPR = 2'd0,
    SEL_SVR = 2'd1,
    SEL_PPR = 2'd2,
    SEL_NIL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/vpc_hi_find.sv
module vpc_hi_find #(
  parameter int NUM_BITS = 256,
  parameter int WORD_W   = 32
) (
  input  logic [NUM_BITS-1:0]         bits,
  output logic                        any,
  output logic [$clog2(NUM_BITS)-1:0] idx
);
  localparam int NUM_WORDS = NUM_BITS / WORD_W;
  localparam int IDX_W     = $clog2(NUM_BITS);
  localparam int BIT_W     = $clog2(WORD_W);

  logic [NUM_WORDS-1:0] w_any;
  logic [BIT_W-1:0]     w_idx [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word;
    assign word     = bits[w*WORD_W +: WORD_W];
    assign w_any[w] = |word;
    always_comb begin
      w_idx[w] = '0;
      for (int b = 0; b < WORD_W; b++)
        if (word[b]) w_idx[w] = BIT_W'(b);
    end
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (w_any[w]) begin
        any = 1'b1;
        idx = IDX_W'(w * WORD_W) + IDX_W'(w_idx[w]);
      end
    end
  end
endmodule

// File: rtl/vpc_ppr_calc.sv
module vpc_ppr_calc #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_any,
  input  logic [VEC_W-1:0] isr_hi,
  output logic [VEC_W-1:0] ppr
);
  localparam int CLS_W = 4;
  localparam int SUB_W = VEC_W - CLS_W;

  logic [CLS_W-1:0] tpr_cls, isr_cls;

  assign tpr_cls = tpr[VEC_W-1 -: CLS_W];
  assign isr_cls = isr_any ? isr_hi[VEC_W-1 -: CLS_W] : '0;
  assign ppr     = (tpr_cls >= isr_cls) ? tpr : {isr_cls, {SUB_W{1'b0}}};

  AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (ppr >= tpr) && (!isr_any || ppr[VEC_W-1 -: CLS_W] >= isr_hi[VEC_W-1 -: CLS_W])); // R3
endmodule

// File: rtl/vec_prio_core.sv
module vec_prio_core
  import vpc_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [$clog2(NUM_VEC)-1:0] req_vector,
  input  logic                       req_level,
  input  logic                       ack_strobe,
  output logic                       ack_valid,
  output logic [$clog2(NUM_VEC)-1:0] ack_vector,
  output logic                       ack_spurious,
  output logic                       ack_none,
  input  logic                       eoi_strobe,
  output logic                       beoi_valid,
  output logic [$clog2(NUM_VEC)-1:0] beoi_vector,
  output logic                       irq,
  input  logic                       reg_wr,
  input  logic [1:0]                 reg_sel,
  input  logic [15:0]                reg_wdata,
  output logic [15:0]                reg_rdata
);
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam int CLS_W = 4;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
  logic [VEC_W-1:0]   tpr_q;
  logic [15:0]        svr_q;

  logic             irr_any, isr_any;
  logic [VEC_W-1:0] irr_hi, isr_hi, ppr;
  logic             enabled, held, grant_ok, beoi_fire;

  vpc_hi_find #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) u_irr_find (
    .bits(irr_q), .any(irr_any), .idx(irr_hi));
  vpc_hi_find #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W)) u_isr_find (
    .bits(isr_q), .any(isr_any), .idx(isr_hi));
  vpc_ppr_calc #(.VEC_W(VEC_W)) u_ppr (
    .clk(clk), .rst_n(rst_n), .tpr(tpr_q), .isr_any(isr_any),
    .isr_hi(isr_hi), .ppr(ppr));

  assign req_ready = 1'b1;
  assign enabled   = svr_q[SVR_EN_BIT];
  assign held      = (ppr != '0) &&
                     (irr_hi[VEC_W-1 -: CLS_W] <= ppr[VEC_W-1 -: CLS_W]);
  assign grant_ok  = enabled && irr_any && !held;
  assign irq       = grant_ok;

  // Next state: request first, then acknowledge, then end of interrupt.
  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (req_valid) begin
      irr_n[req_vector] = 1'b1;
      tmr_n[req_vector] = req_level;
    end
    if (ack_strobe && grant_ok) begin
      irr_n[irr_hi] = 1'b0;
      isr_n[irr_hi] = 1'b1;
    end
    if (eoi_strobe && isr_any) isr_n[isr_hi] = 1'b0;
    beoi_fire = eoi_strobe && isr_any && tmr_n[isr_hi] && !svr_q[SVR_DEOI_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q        <= '0;
      isr_q        <= '0;
      tmr_q        <= '0;
      tpr_q        <= '0;
      svr_q        <= SVR_RESET;
      ack_valid    <= 1'b0;
      ack_vector   <= '0;
      ack_spurious <= 1'b0;
      ack_none     <= 1'b0;
      beoi_valid   <= 1'b0;
      beoi_vector  <= '0;
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
      if (reg_wr && reg_sel == SEL_TPR) tpr_q <= reg_wdata[VEC_W-1:0];
      if (reg_wr && reg_sel == SEL_SVR) svr_q <= reg_wdata & SVR_KEEP;
      ack_valid    <= ack_strobe;
      ack_none     <= ack_strobe && !(enabled && irr_any);
      ack_spurious <= ack_strobe && enabled && irr_any && held;
      ack_vector   <= (ack_strobe && enabled && irr_any && held) ?
                      svr_q[VEC_W-1:0] : ((ack_strobe && grant_ok) ? irr_hi : '0);
      beoi_valid   <= beoi_fire;
      beoi_vector  <= beoi_fire ? isr_hi : '0;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_TPR: reg_rdata = 16'(tpr_q);
      SEL_SVR: reg_rdata = svr_q;
      SEL_PPR: reg_rdata = 16'(ppr);
      default: reg_rdata = '0;
    endcase
  end

  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ack_strobe) |=> irr_q[$past(req_vector)]); // R2
  AST_GRANT_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_spurious && !ack_none) |-> isr_q[ack_vector]); // R6
  AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !(ack_spurious && ack_none)); // R5
  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !svr_q[SVR_EN_BIT] |-> !irq); // R4
  AST_BEOI_DIRECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_strobe && svr_q[SVR_DEOI_BIT]) |=> !beoi_valid); // R7
  AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_strobe && !isr_any) |=> !beoi_valid); // R7
  AST_SVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_SVR) |=> svr_q == ($past(reg_wdata) & SVR_KEEP)); // R8
endmodule

// File: tb/vec_prio_core_bench.sv
module vec_prio_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_level = 1'b0;
  logic [7:0] req_vector = '0;
  logic       ack_strobe = 1'b0, eoi_strobe = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic       req_ready, ack_valid, ack_spurious, ack_none, beoi_valid, irq;
  logic [7:0] ack_vector, beoi_vector;
  logic [15:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  vec_prio_core u_vec_prio_core (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vector(req_vector), .req_level(req_level), .ack_strobe(ack_strobe),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .ack_spurious(ack_spurious),
    .ack_none(ack_none), .eoi_strobe(eoi_strobe), .beoi_valid(beoi_valid),
    .beoi_vector(beoi_vector), .irq(irq), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; ack_strobe = 1'b0; eoi_strobe = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic do_req(int v, bit lvl);
    req_valid = 1'b1; req_vector = 8'(v); req_level = lvl;
    step();
  endtask

  task automatic do_ack();
    ack_strobe = 1'b1;
    step();
  endtask

  task automatic do_eoi();
    eoi_strobe = 1'b1;
    step();
  endtask

  task automatic wr(int sel, int val);
    reg_wr = 1'b1; reg_sel = 2'(sel); reg_wdata = 16'(val);
    step();
  endtask

  task automatic rd(int sel, output int val);
    reg_sel = 2'(sel);
    #1 val = int'(reg_rdata);
  endtask

  task automatic expect_grant(string tag, int v);
    do_ack();
    check({tag, " valid"}, ack_valid, 1);
    check({tag, " vector"}, ack_vector, v);
    check({tag, " flags"}, {ack_spurious, ack_none}, 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset values
    rd(0, r); check("R8 reset tpr", r, 0);
    rd(1, r); check("R8 reset svr", r, 'h00FF);
    check("R4 reset irq", irq, 0);
    check("R2 ready", req_ready, 1);

    // R4 disabled then enabled
    wr(1, 'h00FF);
    do_req('h40, 0);
    check("R4 disabled irq", irq, 0);
    do_ack();
    check("R4 disabled ack none", {ack_valid, ack_none, ack_spurious}, 3'b110);
    wr(1, 'h01FF);
    check("R10 enable raises irq", irq, 1);
    expect_grant("R6 after enable", 'h40);
    check("R10 irq drops after grant", irq, 0);
    do_eoi();
    do_ack();
    check("R4 empty ack none", {ack_none, ack_spurious}, 2'b10);

    // R8 spurious register masking
    wr(1, 'hFFFF);
    rd(1, r); check("R8 svr mask", r, 'h11FF);
    wr(1, 'h01FF);

    // R1 R6 sweep every vector
    for (int v = 0; v < 256; v++) begin
      do_req(v, 0);
      check("R10 irq after request", irq, 1);
      expect_grant("R6 sweep", v);
      do_eoi();
      check("R7 edge no broadcast", beoi_valid, 0);
      rd(2, r); check("R7 isr emptied", r, 0);
    end

    // R1 ordering
    do_req('h3F, 0); do_req('h40, 0); do_req('hE1, 0); do_req('h20, 0);
    expect_grant("R1 first", 'hE1); do_eoi();
    expect_grant("R1 second", 'h40); do_eoi();
    expect_grant("R1 third", 'h3F); do_eoi();
    expect_grant("R1 fourth", 'h20); do_eoi();

    // R5 task priority sweep against vector 0x85
    wr(1, 'h01A7);
    for (int t = 0; t < 256; t++) begin
      bit g;
      g = (t >> 4) < 8;
      wr(0, t);
      do_req('h85, 0);
      check("R5 irq vs tpr", irq, int'(g));
      do_ack();
      if (g) begin
        check("R5 grant vector", ack_vector, 'h85);
        check("R5 grant flags", {ack_spurious, ack_none}, 0);
        do_eoi();
      end else begin
        check("R5 spurious vector", ack_vector, 'hA7);
        check("R5 spurious flag", {ack_spurious, ack_none}, 2'b10);
      end
    end
    wr(0, 0);
    expect_grant("R5 release", 'h85);
    do_eoi();

    // R3 processor priority
    wr(0, 'h35);
    do_req('h72, 0);
    expect_grant("R3 grant 72", 'h72);
    rd(2, r); check("R3 isr class wins", r, 'h70);
    wr(0, 'h95); rd(2, r); check("R3 tpr wins", r, 'h95);
    wr(0, 'h70); rd(2, r); check("R3 equal class", r, 'h70);
    wr(0, 'h7A); rd(2, r); check("R3 equal class low nibble", r, 'h7A);
    wr(0, 0);
    do_eoi();

    // R7 nested EOI
    do_req('h50, 0); expect_grant("R7 nest low", 'h50);
    do_req('h90, 0); expect_grant("R7 nest high", 'h90);
    do_eoi();
    rd(2, r); check("R7 only highest retired", r, 'h50);
    do_eoi();
    rd(2, r); check("R7 all retired", r, 0);
    do_eoi();
    check("R7 empty eoi", beoi_valid, 0);

    // R7 level broadcast and directed mode
    do_req('h66, 1); expect_grant("R7 level", 'h66);
    do_eoi();
    check("R7 broadcast valid", beoi_valid, 1);
    check("R7 broadcast vector", beoi_vector, 'h66);
    wr(1, 'h11FF);
    do_req('h66, 1); expect_grant("R7 level directed", 'h66);
    do_eoi();
    check("R7 directed suppresses", beoi_valid, 0);
    wr(1, 'h01FF);
    do_req('h66, 1); do_req('h66, 0);
    expect_grant("R2 edge rewrite", 'h66);
    do_eoi();
    check("R2 edge clears trigger", beoi_valid, 0);

    // R9 same-cycle request and EOI
    do_req('h66, 1); expect_grant("R9 setup", 'h66);
    req_valid = 1'b1; req_vector = 8'h66; req_level = 1'b0; eoi_strobe = 1'b1;
    step();
    check("R9 request first no broadcast", beoi_valid, 0);
    check("R9 request kept", irq, 1);
    expect_grant("R9 regrant", 'h66);
    do_eoi();

    finish_run();
  end
endmodule